// File: doc/BRIEF.md
# In-Group Store-Load Overlap Detector

This block keeps a short list of the stores already placed in the dispatch group that is being formed, and answers at once whether a candidate load could read bytes that one of those stores writes. A scheduler uses the answer to hold the load back, or to pad the group with a no-op, so that the processor does not replay a load that depends on a store in the same group.

Every access is described by a size code and two address operands. The first operand is tagged: either an unsigned constant offset, or a register identifier carried in its low bits. The second operand is always a base register identifier. A store enters the table on a clock edge. A load is a purely combinational query against the entries already held. The table is emptied when the group ends.

The detector reports a conflict in three cases: the two operand pairs agree in the same order; they agree with the two operands swapped; or both accesses use a constant offset from the same base register and their byte ranges intersect. It knows nothing about real effective addresses and nothing about where groups start or end.

Top module: `stld_overlap_table`

## Requirements
- R1: A load hits a valid entry when the first operands carry the same constant flag and the same value, and the second operands are equal. For a register first operand only the low REG_W (5) bits count; for a constant all OFF_W (16) bits count.
- R2: A load whose first operand is a register hits an entry whose first operand is also a register when the load's first operand equals the entry's base register and the entry's first operand equals the load's base register.
- R3: When both first operands are constants and the base registers are equal, let s and l be the store and load offsets. The load hits if s < l and s + store bytes > l, or if s >= l and l + load bytes > s. Sums use OFF_W+1 bits and never wrap.
- R4: Size codes 0, 1, 2, 3 and 4 mean 1, 2, 4, 8 and 16 bytes. Codes 5 to 7 also mean 16 bytes.
- R5: With an empty table hit_o is 0 for every load. Entries at or beyond the fill count never contribute.
- R6: A push while not full and not clearing writes the entry at index fill_o, and fill_o rises by one at that edge. The new entry affects hit_o only after that edge.
- R7: grp_end_i empties the table and clears overflow_o at the edge. A push in the same cycle is discarded.
- R8: A push while fill_o equals DEPTH (4) stores nothing, leaves the existing entries unchanged and sets overflow_o, which stays set until a clear or reset.
- R9: After reset fill_o is 0, overflow_o is 0 and hit_o is 0.
- R10: hit_o is the OR of the per-entry matches and follows the load inputs in the same cycle, with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| grp_end_i | input | 1 | End of dispatch group: empty the table |
| st_push_i | input | 1 | Record a store this cycle |
| st_size_i | input | 3 | Store size code |
| st_opa_const_i | input | 1 | Store first operand is a constant offset |
| st_opa_i | input | 16 | Store first operand: offset, or register id in the low bits |
| st_opb_i | input | 5 | Store base register id |
| ld_size_i | input | 3 | Load size code |
| ld_opa_const_i | input | 1 | Load first operand is a constant offset |
| ld_opa_i | input | 16 | Load first operand: offset, or register id in the low bits |
| ld_opb_i | input | 5 | Load base register id |
| hit_o | output | 1 | Load conflicts with a recorded store |
| fill_o | output | 3 | Number of valid entries |
| overflow_o | output | 1 | A store was dropped because the table was full |

## Verification
A wrong fill count shows up on fill_o one edge after the push or clear that caused it. It also shows on hit_o in the very next query: a store that is remembered by mistake still hits after a clear, and a store that was lost misses its own address. A corrupted entry field appears only when a load probes that field. For that reason the offset sweep runs every pair of size codes against a window of offsets on both sides of the store, including offsets near the top of the range, and the operand sweep probes every combination of constant flag and small register id. A missed overflow shows on overflow_o at the edge after the fifth push, and also on hit_o if the dropped store's address is reported as a hit.

// File: rtl/stld_pkg.sv
package stld_pkg;

   localparam int SZ_W    = 3;
   localparam int BYTES_W = 5;

   typedef enum logic [SZ_W-1:0] {
      ACC_1B  = 3'd0,
      ACC_2B  = 3'd1,
      ACC_4B  = 3'd2,
      ACC_8B  = 3'd3,
      ACC_16B = 3'd4
   } acc_size_e;

   // Byte count of a size code; any code above the largest saturates to 16.
   function automatic logic [BYTES_W-1:0] size_bytes(input logic [SZ_W-1:0] code);
      case (acc_size_e'(code))
         ACC_1B:  size_bytes = 5'd1;
         ACC_2B:  size_bytes = 5'd2;
         ACC_4B:  size_bytes = 5'd4;
         ACC_8B:  size_bytes = 5'd8;
         default: size_bytes = 5'd16;
      endcase
   endfunction

endpackage

// File: rtl/stld_pair_cmp.sv
module stld_pair_cmp
   import stld_pkg::*;
#(
   parameter int OFF_W = 16,
   parameter int REG_W = 5
) (
   input  logic [SZ_W-1:0]  st_size,
   input  logic             st_opa_c,
   input  logic [OFF_W-1:0] st_opa,
   input  logic [REG_W-1:0] st_opb,
   input  logic [SZ_W-1:0]  ld_size,
   input  logic             ld_opa_c,
   input  logic [OFF_W-1:0] ld_opa,
   input  logic [REG_W-1:0] ld_opb,
   output logic             match_o
);

   localparam int SUM_W = OFF_W + 1;

   logic             base_eq;
   logic             first_eq;
   logic             same_order;
   logic             swapped;
   logic             range_hit;
   logic [SUM_W-1:0] st_end;
   logic [SUM_W-1:0] ld_end;

   assign base_eq = (st_opb == ld_opb);

   // A register operand is compared on its identifier bits only.
   always_comb begin
      if (st_opa_c != ld_opa_c)
         first_eq = 1'b0;
      else if (st_opa_c)
         first_eq = (st_opa == ld_opa);
      else
         first_eq = (st_opa[REG_W-1:0] == ld_opa[REG_W-1:0]);
   end

   assign same_order = first_eq && base_eq;

   assign swapped = !st_opa_c && !ld_opa_c &&
                    (ld_opa[REG_W-1:0] == st_opb) &&
                    (st_opa[REG_W-1:0] == ld_opb);

   assign st_end = {1'b0, st_opa} + SUM_W'(size_bytes(st_size));
   assign ld_end = {1'b0, ld_opa} + SUM_W'(size_bytes(ld_size));

   always_comb begin
      range_hit = 1'b0;
      if (st_opa_c && ld_opa_c && base_eq) begin
         if (st_opa < ld_opa)
            range_hit = (st_end > {1'b0, ld_opa});
         else
            range_hit = (ld_end > {1'b0, st_opa});
      end
   end

   assign match_o = same_order || swapped || range_hit;

endmodule

// File: rtl/stld_store_table.sv
module stld_store_table
   import stld_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int OFF_W = 16,
   parameter int REG_W = 5,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        clr_i,
   input  logic                        push_i,
   input  logic [SZ_W-1:0]             w_size_i,
   input  logic                        w_opa_c_i,
   input  logic [OFF_W-1:0]            w_opa_i,
   input  logic [REG_W-1:0]            w_opb_i,
   output logic [DEPTH-1:0][SZ_W-1:0]  e_size_o,
   output logic [DEPTH-1:0]            e_opa_c_o,
   output logic [DEPTH-1:0][OFF_W-1:0] e_opa_o,
   output logic [DEPTH-1:0][REG_W-1:0] e_opb_o,
   output logic [DEPTH-1:0]            e_vld_o,
   output logic [CNT_W-1:0]            count_o,
   output logic                        ovf_o
);

   localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

   logic [CNT_W-1:0] cnt_q;
   logic             ovf_q;
   logic             is_full;
   logic             take;

   logic [SZ_W-1:0]  size_q [DEPTH];
   logic             opa_c_q [DEPTH];
   logic [OFF_W-1:0] opa_q [DEPTH];
   logic [REG_W-1:0] opb_q [DEPTH];

   assign is_full = (cnt_q == FULL_CNT);
   assign take    = push_i && !clr_i && !is_full;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (clr_i)
         cnt_q <= '0;
      else if (take)
         cnt_q <= cnt_q + 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         ovf_q <= 1'b0;
      else if (clr_i)
         ovf_q <= 1'b0;
      else if (push_i && is_full)
         ovf_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < DEPTH; i++) begin
            size_q[i]  <= '0;
            opa_c_q[i] <= 1'b0;
            opa_q[i]   <= '0;
            opb_q[i]   <= '0;
         end
      end else if (take) begin
         for (int i = 0; i < DEPTH; i++) begin
            if (cnt_q == CNT_W'(i)) begin
               size_q[i]  <= w_size_i;
               opa_c_q[i] <= w_opa_c_i;
               opa_q[i]   <= w_opa_i;
               opb_q[i]   <= w_opb_i;
            end
         end
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      assign e_size_o[g]  = size_q[g];
      assign e_opa_c_o[g] = opa_c_q[g];
      assign e_opa_o[g]   = opa_q[g];
      assign e_opb_o[g]   = opb_q[g];
      assign e_vld_o[g]   = (cnt_q > CNT_W'(g));
   end

   assign count_o = cnt_q;
   assign ovf_o   = ovf_q;

   // R7: a clear leaves an empty table and no overflow
   p_clear_empties_r7: assert property (@(posedge clk) disable iff (!rst_n)
      clr_i |=> (cnt_q == '0) && !ovf_q);

   // R6: an accepted store grows the count by exactly one
   p_push_grows_r6: assert property (@(posedge clk) disable iff (!rst_n)
      take |=> cnt_q == CNT_W'($past(cnt_q) + 1'b1));

   // R8: a store into a full table is dropped and flagged
   p_full_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (push_i && !clr_i && is_full) |=> ovf_q && (cnt_q == FULL_CNT));

   // R6: the count never exceeds the table depth
   p_count_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL_CNT);

endmodule

// File: rtl/stld_overlap_table.sv
module stld_overlap_table
   import stld_pkg::*;
#(
   parameter int DEPTH = 4,
   parameter int OFF_W = 16,
   parameter int REG_W = 5,
   parameter int CNT_W = $clog2(DEPTH + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             grp_end_i,
   input  logic             st_push_i,
   input  logic [2:0]       st_size_i,
   input  logic             st_opa_const_i,
   input  logic [OFF_W-1:0] st_opa_i,
   input  logic [REG_W-1:0] st_opb_i,
   input  logic [2:0]       ld_size_i,
   input  logic             ld_opa_const_i,
   input  logic [OFF_W-1:0] ld_opa_i,
   input  logic [REG_W-1:0] ld_opb_i,
   output logic             hit_o,
   output logic [CNT_W-1:0] fill_o,
   output logic             overflow_o
);

   if (DEPTH < 1) begin : g_bad_depth
      $error("stld_overlap_table: DEPTH must be at least 1");
   end
   if (REG_W > OFF_W) begin : g_bad_reg_w
      $error("stld_overlap_table: REG_W must not exceed OFF_W");
   end
   if (CNT_W < $clog2(DEPTH + 1)) begin : g_bad_cnt_w
      $error("stld_overlap_table: CNT_W too narrow for DEPTH");
   end

   logic [DEPTH-1:0][SZ_W-1:0]  e_size;
   logic [DEPTH-1:0]            e_opa_c;
   logic [DEPTH-1:0][OFF_W-1:0] e_opa;
   logic [DEPTH-1:0][REG_W-1:0] e_opb;
   logic [DEPTH-1:0]            e_vld;
   logic [DEPTH-1:0]            lane_hit;

   stld_store_table #(
      .DEPTH (DEPTH),
      .OFF_W (OFF_W),
      .REG_W (REG_W),
      .CNT_W (CNT_W)
   ) u_table (
      .clk       (clk),
      .rst_n     (rst_n),
      .clr_i     (grp_end_i),
      .push_i    (st_push_i),
      .w_size_i  (st_size_i),
      .w_opa_c_i (st_opa_const_i),
      .w_opa_i   (st_opa_i),
      .w_opb_i   (st_opb_i),
      .e_size_o  (e_size),
      .e_opa_c_o (e_opa_c),
      .e_opa_o   (e_opa),
      .e_opb_o   (e_opb),
      .e_vld_o   (e_vld),
      .count_o   (fill_o),
      .ovf_o     (overflow_o)
   );

   for (genvar g = 0; g < DEPTH; g++) begin : g_lane
      stld_pair_cmp #(
         .OFF_W (OFF_W),
         .REG_W (REG_W)
      ) u_cmp (
         .st_size  (e_size[g]),
         .st_opa_c (e_opa_c[g]),
         .st_opa   (e_opa[g]),
         .st_opb   (e_opb[g]),
         .ld_size  (ld_size_i),
         .ld_opa_c (ld_opa_const_i),
         .ld_opa   (ld_opa_i),
         .ld_opb   (ld_opb_i),
         .match_o  (lane_hit[g])
      );
   end

   assign hit_o = |(lane_hit & e_vld);

   // R5: an empty table never reports a conflict
   p_empty_no_hit_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_o == '0) |-> !hit_o);

endmodule

// File: tb/test_stld_overlap_table.sv
module test_stld_overlap_table;

   localparam int DEPTH = 4;
   localparam int OFF_W = 16;
   localparam int REG_W = 5;
   localparam int CNT_W = 3;

   logic             clk;
   logic             rst_n;
   logic             grp_end;
   logic             st_push;
   logic [2:0]       st_size;
   logic             st_c;
   logic [OFF_W-1:0] st_a;
   logic [REG_W-1:0] st_b;
   logic [2:0]       ld_size;
   logic             ld_c;
   logic [OFF_W-1:0] ld_a;
   logic [REG_W-1:0] ld_b;
   logic             hit;
   logic [CNT_W-1:0] fill;
   logic             ovf;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 0;

   int m_cnt = 0;
   bit m_ovf = 0;
   int m_sz [DEPTH];
   bit m_c  [DEPTH];
   int m_a  [DEPTH];
   int m_b  [DEPTH];

   stld_overlap_table #(
      .DEPTH (DEPTH),
      .OFF_W (OFF_W),
      .REG_W (REG_W),
      .CNT_W (CNT_W)
   ) i_stld_overlap_table (
      .clk            (clk),
      .rst_n          (rst_n),
      .grp_end_i      (grp_end),
      .st_push_i      (st_push),
      .st_size_i      (st_size),
      .st_opa_const_i (st_c),
      .st_opa_i       (st_a),
      .st_opb_i       (st_b),
      .ld_size_i      (ld_size),
      .ld_opa_const_i (ld_c),
      .ld_opa_i       (ld_a),
      .ld_opb_i       (ld_b),
      .hit_o          (hit),
      .fill_o         (fill),
      .overflow_o     (ovf)
   );

   initial clk = 1'b0;
   always #10ns clk = ~clk;

   function automatic int bytes_of(int code);
      return (code >= 4) ? 16 : (1 << code);
   endfunction

   // Expected conflict, from R1..R5 applied to the bench's own list of stores.
   function automatic bit ref_hit(int sz, bit c, int a, int b);
      for (int i = 0; i < m_cnt; i++) begin
         bit fa;
         if (m_c[i] != c) fa = 0;
         else if (c)      fa = (m_a[i] == a);
         else             fa = ((m_a[i] % 32) == (a % 32));
         if (fa && m_b[i] == b) return 1;
         if (!c && !m_c[i] && (a % 32) == m_b[i] && (m_a[i] % 32) == b) return 1;
         if (c && m_c[i] && m_b[i] == b) begin
            if (m_a[i] < a) begin
               if (m_a[i] + bytes_of(m_sz[i]) > a) return 1;
            end else begin
               if (a + bytes_of(sz) > m_a[i]) return 1;
            end
         end
      end
      return 0;
   endfunction

   task automatic check_hit(int sz, bit c, int a, int b, string tag);
      bit exp;
      ld_size = 3'(sz);
      ld_c    = c;
      ld_a    = 16'(a);
      ld_b    = 5'(b);
      #1ns;
      exp = ref_hit(sz, c, a, b);
      n_cmp++;
      if (hit !== exp) begin
         n_bad++;
         $display("FAIL %s hit: sz=%0d c=%0d a=%0h b=%0d actual=%0b expected=%0b",
                  tag, sz, c, a, b, hit, exp);
      end
   endtask

   task automatic check_state(string tag);
      n_cmp++;
      if (fill !== CNT_W'(m_cnt) || ovf !== m_ovf) begin
         n_bad++;
         $display("FAIL %s state: actual fill=%0d ovf=%0b expected fill=%0d ovf=%0b",
                  tag, fill, ovf, m_cnt, m_ovf);
      end
   endtask

   task automatic push(int sz, bit c, int a, int b);
      @(negedge clk);
      st_push = 1'b1;
      st_size = 3'(sz);
      st_c    = c;
      st_a    = 16'(a);
      st_b    = 5'(b);
      @(posedge clk);
      #2ns;
      st_push = 1'b0;
      if (m_cnt < DEPTH) begin
         m_sz[m_cnt] = sz;
         m_c[m_cnt]  = c;
         m_a[m_cnt]  = a;
         m_b[m_cnt]  = b;
         m_cnt++;
      end else begin
         m_ovf = 1;
      end
   endtask

   task automatic clear_grp(bit with_push, int sz, bit c, int a, int b);
      @(negedge clk);
      grp_end = 1'b1;
      st_push = with_push;
      st_size = 3'(sz);
      st_c    = c;
      st_a    = 16'(a);
      st_b    = 5'(b);
      @(posedge clk);
      #2ns;
      grp_end = 1'b0;
      st_push = 1'b0;
      m_cnt   = 0;
      m_ovf   = 0;
   endtask

   initial begin
      #4ms;
      if (!done) begin
         n_bad++;
         $display("FAIL R9 watchdog: actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      rst_n   = 1'b0;
      grp_end = 1'b0;
      st_push = 1'b0;
      st_size = '0;
      st_c    = 1'b0;
      st_a    = '0;
      st_b    = '0;
      ld_size = '0;
      ld_c    = 1'b0;
      ld_a    = '0;
      ld_b    = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state on all outputs
      check_state("R9");
      check_hit(0, 0, 0, 0, "R9");
      rst_n = 1'b1;
      @(posedge clk);
      #2ns;

      // R5: empty table misses every kind of load
      for (int c = 0; c < 2; c++)
         for (int a = 0; a < 4; a++)
            check_hit(2, c[0], a, a, "R5");

      // R6: a store is not visible in its own cycle, then is visible
      @(negedge clk);
      st_push = 1'b1; st_size = 3'd2; st_c = 1'b1; st_a = 16'd40; st_b = 5'd3;
      check_hit(2, 1, 40, 3, "R6");
      @(posedge clk);
      #2ns;
      st_push = 1'b0;
      m_sz[0] = 2; m_c[0] = 1; m_a[0] = 40; m_b[0] = 3; m_cnt = 1;
      check_state("R6");
      check_hit(2, 1, 40, 3, "R6");
      check_hit(0, 1, 44, 3, "R6");
      check_hit(0, 1, 43, 3, "R6");

      // R3 and R4: every pair of size codes over a window of offsets
      for (int sc = 0; sc < 8; sc++) begin
         clear_grp(0, 0, 0, 0, 0);
         push(sc, 1, 100, 7);
         for (int lc = 0; lc < 8; lc++)
            for (int l = 80; l <= 120; l++)
               check_hit(lc, 1, l, 7, "R3");
         check_hit(4, 1, 100, 8, "R3");
      end

      // R3: offsets at the top of the range must not wrap
      clear_grp(0, 0, 0, 0, 0);
      push(4, 1, 16'hFFF8, 2);
      for (int lc = 0; lc < 5; lc++)
         for (int l = 16'hFFE0; l <= 16'hFFFF; l++)
            check_hit(lc, 1, l, 2, "R3");

      // R4: codes above 4 mean sixteen bytes
      clear_grp(0, 0, 0, 0, 0);
      push(5, 1, 100, 7);
      check_hit(0, 1, 115, 7, "R4");
      check_hit(0, 1, 116, 7, "R4");
      check_hit(7, 1, 84, 7, "R4");
      check_hit(7, 1, 85, 7, "R4");

      // R1: operand sweep over exact matches; register ids use low bits only
      clear_grp(0, 0, 0, 0, 0);
      push(0, 0, 3, 1);
      push(0, 1, 2, 2);
      push(0, 0, 16'h0125, 4);
      for (int c = 0; c < 2; c++)
         for (int ai = 0; ai < 7; ai++)
            for (int b = 0; b < 6; b++) begin
               int a;
               case (ai)
                  5:       a = 16'h0105;
                  6:       a = 16'h0123;
                  default: a = ai + 1;
               endcase
               check_hit(0, c[0], a, b, "R1");
            end

      // R2: swapped register operands
      check_hit(0, 0, 1, 3, "R2");
      check_hit(0, 0, 4, 5, "R2");
      check_hit(0, 0, 16'h0304, 5, "R2");
      check_hit(0, 1, 1, 3, "R2");
      check_hit(0, 0, 1, 2, "R2");

      // R10: a hit from the last entry alone raises hit_o
      clear_grp(0, 0, 0, 0, 0);
      for (int i = 0; i < DEPTH; i++)
         push(1, 1, 0, 10 + i);
      check_state("R10");
      check_hit(1, 1, 1, 13, "R10");
      check_hit(1, 1, 2, 13, "R10");
      check_hit(1, 1, 0, 14, "R10");

      // R8: a fifth store is dropped and flagged
      push(1, 1, 0, 20);
      check_state("R8");
      check_hit(1, 1, 0, 20, "R8");
      check_hit(1, 1, 0, 10, "R8");
      push(1, 1, 0, 21);
      check_state("R8");
      check_hit(1, 1, 0, 21, "R8");

      // R7: clear empties the table; a push in the same cycle is lost
      clear_grp(1, 1, 1, 0, 9);
      check_state("R7");
      check_hit(1, 1, 0, 9, "R7");
      check_hit(1, 1, 0, 10, "R7");
      check_hit(1, 1, 0, 13, "R7");
      push(1, 1, 0, 9);
      check_state("R7");
      check_hit(1, 1, 0, 9, "R7");

      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule